// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block forms the word address used by a synchronous burst memory during a four-beat burst. When the cycle controller raises the load qualifier, the block captures the full external address. The two lowest bits of that address become the starting offset of the burst. On each later clock edge where the active-low advance qualifier is sampled low, the block moves to the next beat. Where advance is sampled high, the present address stays as it is. The upper address bits are taken from the captured address and do not change until the next load.

A static order input picks one of two beat orders. In linear order the low bits count upward modulo the burst length. In interleaved order the low bits are the starting offset XOR the beat number. Both orders share one internal beat counter. After the fourth beat the sequence returns to its starting address. A flag marks the final beat of the burst. Deciding when a burst begins is left to the surrounding cycle controller.

Top module: `burst_addr_gen`

## Requirements
- R1: The address bits above bit 1 (bits 17..2 by default) equal the value of `addr_i` captured at the most recent load edge, and they stay fixed while no load occurs, whatever `addr_i` does.
- R2: After a clock edge with `load_i` high, `addr_o` equals the `addr_i` sampled on that edge, and the beat number becomes 0.
- R3: With `order_i` = 0 (linear), each advance step sets the low two bits of `addr_o` to the previous low bits plus 1, modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R4: With `order_i` = 1 (interleaved), the low two bits of `addr_o` are the starting offset XOR the beat number 0..3. For example, start 01 gives 01, 00, 11, 10, and start 10 gives 10, 11, 00, 01.
- R5: A fourth advance step after the start returns `addr_o` to the starting address.
- R6: After an edge with `load_i` low and `adv_n_i` high, `addr_o` and `last_o` are unchanged.
- R7: On an edge with `load_i` high, the value of `adv_n_i` has no effect. The burst starts at beat 0 even with `adv_n_i` low.
- R8: `last_o` is high exactly when the beat number is 3, which is the fourth address of the burst.
- R9: While reset is held, and after it is released, `addr_o` is 0 and `last_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| order_i | input | 1 | Static beat order: 0 selects linear, 1 selects interleaved |
| load_i | input | 1 | Capture `addr_i` and restart at beat 0 |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| addr_i | input | ADDR_W | External word address |
| addr_o | output | ADDR_W | Current word address of the burst |
| last_o | output | 1 | High on the fourth beat of the burst |

## Verification
The bench runs bursts from every starting offset in both orders. A design that mixed up the two orders, or that carried into bit 2 instead of wrapping modulo 4, would produce a wrong low-bit value on the second or third beat. The fifth address is checked against the start: a counter that failed to wrap, or that saturated, would land elsewhere or leave the last-beat flag stuck high. Loads are applied with advance low, both at idle and in the middle of a burst. A design that obeyed advance on the load edge would begin one beat late. Hold cycles are run while the external address keeps changing, which catches a register that lets new upper bits leak through or that advances while it should hold.

// File: rtl/bag_pkg.sv
package bag_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

endpackage

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          adv_n_i,
    output logic [CW-1:0] beat_o,
    output logic          final_o
);

    localparam logic [CW-1:0] BEAT_LAST = '1;

    typedef struct packed {
        logic [CW-1:0] beat;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.beat = '0;
        end else if (!adv_n_i) begin
            st_d.beat = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign beat_o  = st_q.beat;
    assign final_o = (st_q.beat == BEAT_LAST);

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i) |=> (beat_o == $past(beat_o) + 1'b1)); // R3
    AST_BEAT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (beat_o == '0)); // R7

endmodule

// File: rtl/bag_base_reg.sv
module bag_base_reg #(
    parameter int AW = 18,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-CW-1:0] upper_o,
    output logic [CW-1:0] ofs_o
);

    typedef struct packed {
        logic [AW-CW-1:0] upper;
        logic [CW-1:0]    ofs;
    } base_t;

    base_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.upper = addr_i[AW-1:CW];
            st_d.ofs   = addr_i[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign upper_o = st_q.upper;
    assign ofs_o   = st_q.ofs;

    AST_BASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(upper_o) && $stable(ofs_o))); // R1

endmodule

// File: rtl/bag_seq_map.sv
module bag_seq_map #(
    parameter int CW = 2
) (
    input  bag_pkg::order_e order_i,
    input  logic [CW-1:0]   ofs_i,
    input  logic [CW-1:0]   beat_i,
    output logic [CW-1:0]   low_o
);

    logic [CW-1:0] lin_w;
    logic [CW-1:0] ilv_w;

    genvar b;
    generate
        for (b = 0; b < CW; b++) begin : g_ilv
            assign ilv_w[b] = ofs_i[b] ^ beat_i[b];
        end
    endgenerate

    assign lin_w = ofs_i + beat_i;

    always_comb begin
        case (order_i)
            bag_pkg::ORD_INTERLEAVE: low_o = ilv_w;
            default:                 low_o = lin_w;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int ADDR_W    = 18,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              order_i,
    input  logic              load_i,
    input  logic              adv_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    localparam int CW = $clog2(BURST_LEN);
    localparam int UW = ADDR_W - CW;

    logic [UW-1:0] upper_w;
    logic [CW-1:0] ofs_w;
    logic [CW-1:0] beat_w;
    logic [CW-1:0] low_w;
    bag_pkg::order_e order_w;

    assign order_w = bag_pkg::order_e'(order_i);

    bag_base_reg #(.AW(ADDR_W), .CW(CW)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .addr_i  (addr_i),
        .upper_o (upper_w),
        .ofs_o   (ofs_w)
    );

    bag_beat_ctr #(.CW(CW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_n_i (adv_n_i),
        .beat_o  (beat_w),
        .final_o (last_o)
    );

    bag_seq_map #(.CW(CW)) u_map (
        .order_i (order_w),
        .ofs_i   (ofs_w),
        .beat_i  (beat_w),
        .low_o   (low_w)
    );

    assign addr_o = {upper_w, low_w};

    AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(addr_i))); // R2
    AST_LOAD_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !last_o); // R8
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o[ADDR_W-1:CW])); // R1
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> ($stable(addr_o) || !$stable(order_i))); // R6
    AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && !order_i) |=>
        (order_i || addr_o[CW-1:0] == $past(addr_o[CW-1:0]) + 1'b1)); // R3
    AST_LAST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !load_i && !adv_n_i) |=> !last_o); // R5

endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              order_i = 1'b0;
    logic              load_i = 1'b0;
    logic              adv_n_i = 1'b1;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [ADDR_W-1:0] addr_o;
    logic              last_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W), .BURST_LEN(4)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .order_i (order_i),
        .load_i  (load_i),
        .adv_n_i (adv_n_i),
        .addr_i  (addr_i),
        .addr_o  (addr_o),
        .last_o  (last_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic ld, input logic advn, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        load_i  = ld;
        adv_n_i = advn;
        addr_i  = a;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [1:0] expect_low(input logic ord, input logic [1:0] s, input int k);
        logic [1:0] kk;
        kk = 2'(k);
        return ord ? (s ^ kk) : (s + kk);
    endfunction

    task automatic t_reset();
        chk("R9 addr in reset", 32'(addr_o), 32'h0);
        chk("R9 last in reset", 32'(last_o), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R9 addr after reset", 32'(addr_o), 32'h0);
        chk("R9 last after reset", 32'(last_o), 32'h0);
    endtask

    task automatic t_burst(input logic ord, input logic [ADDR_W-1:0] base);
        logic [1:0] s;
        s = base[1:0];
        @(negedge clk);
        order_i = ord;
        cyc(1'b1, 1'b1, base);
        chk("R2 start address", 32'(addr_o), 32'(base));
        chk("R8 not last at beat 0", 32'(last_o), 32'h0);
        for (int k = 1; k < 4; k++) begin
            cyc(1'b0, 1'b0, ~base);
            chk(ord ? "R4 interleaved beat" : "R3 linear beat",
                32'(addr_o[1:0]), 32'(expect_low(ord, s, k)));
            chk("R1 upper bits fixed", 32'(addr_o[ADDR_W-1:2]), 32'(base[ADDR_W-1:2]));
            chk("R8 last flag", 32'(last_o), (k == 3) ? 32'h1 : 32'h0);
        end
        cyc(1'b0, 1'b0, base ^ 18'h155);
        chk("R5 wrap to start", 32'(addr_o), 32'(base));
        chk("R8 last cleared on wrap", 32'(last_o), 32'h0);
    endtask

    task automatic t_hold();
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] seen;
        base = 18'h2A5C1;
        @(negedge clk);
        order_i = 1'b0;
        cyc(1'b1, 1'b1, base);
        cyc(1'b0, 1'b0, base);
        cyc(1'b0, 1'b0, base);
        cyc(1'b0, 1'b0, base);
        seen = addr_o;
        chk("R3 reached beat 3", 32'(seen), 32'({base[ADDR_W-1:2], 2'b00}));
        for (int k = 0; k < 3; k++) begin
            cyc(1'b0, 1'b1, 18'h3FFFF - 18'(k));
            chk("R6 hold address", 32'(addr_o), 32'(seen));
            chk("R6 hold last", 32'(last_o), 32'h1);
        end
        cyc(1'b0, 1'b0, 18'h0);
        chk("R5 wrap after hold", 32'(addr_o), 32'(base));
    endtask

    task automatic t_load_adv();
        logic [ADDR_W-1:0] b1;
        logic [ADDR_W-1:0] b2;
        b1 = 18'h01236;
        b2 = 18'h3C003;
        @(negedge clk);
        order_i = 1'b1;
        cyc(1'b1, 1'b0, b1);
        chk("R7 load ignores advance", 32'(addr_o), 32'(b1));
        cyc(1'b0, 1'b0, b2);
        chk("R4 interleaved second beat", 32'(addr_o), 32'({b1[ADDR_W-1:2], 2'b11}));
        cyc(1'b1, 1'b0, b2);
        chk("R7 reload mid-burst", 32'(addr_o), 32'(b2));
        chk("R7 reload beat 0 not last", 32'(last_o), 32'h0);
        cyc(1'b0, 1'b0, b1);
        chk("R4 interleaved after reload", 32'(addr_o), 32'({b2[ADDR_W-1:2], 2'b10}));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        for (int s = 0; s < 4; s++) begin
            t_burst(1'b0, 18'h1B340 | 18'(s));
            t_burst(1'b1, 18'h26CB0 | 18'(s));
        end
        t_hold();
        t_load_adv();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule